// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider Controller

This block sits in the feedback path of a frequency synthesizer. An external dual-modulus prescaler divides the oscillator output by either P or P+1. The controller is clocked by the prescaler's output. It steers the prescaler's modulus input and counts prescaler pulses. Each output period has N prescaler cycles. The first A of them run at P+1 and the rest run at P, so one output period spans P×N+A oscillator cycles.

N is an 11-bit value with a legal range of 3 to 2047. A is a 7-bit value from 0 to 127 and must be smaller than N. A one-bit range selector chooses the lower or the higher prescaler ratio. The lower ratio is 16 or 32, depending on the path. The higher ratio is always twice the lower one. The controller samples N, A and the selector only at a period boundary, so a period in progress always runs to its end. At every boundary it raises a one-cycle pulse for the phase detector.

The control state machine has three states:

- IDLE is the reset state, with modulus control low.
- HIGH is the swallow phase, where modulus control selects P+1.
- LOW is the main phase, where modulus control selects P.

Its transitions are:

- Boundary to HIGH: taken from any state at a period boundary when A is non-zero.
- Boundary to LOW: taken from any state at a period boundary when A is zero.
- Swallow done: taken from HIGH to LOW when the swallow count runs out.
- Hold: every state keeps its value otherwise.

Top module: `pss_divider_ctrl`

## Requirements
- R1: While reset is asserted, `mc_o`, `div_pulse_o` and `mod_sel_o` are low. The first prescaler edge after reset ends a period and starts a new one.
- R2: Every output period lasts exactly N prescaler cycles. `div_pulse_o` is high for exactly one prescaler cycle per period, and that cycle is the first one of the period.
- R3: `mc_o` = 1 asks the prescaler for P+1 and `mc_o` = 0 asks for P. `mc_o` is high for the first A prescaler cycles of a period and low for the rest. An output period therefore spans P×N+A oscillator cycles.
- R4: When A is 0, `mc_o` stays low for the whole period.
- R5: `n_ratio`, `a_ratio` and `mod_sel_i` are sampled only on the edge that ends a period. A change made during a period leaves that period's length and swallow count unchanged, and it applies from the next period.
- R6: `mod_sel_o` holds the range selector sampled at the last boundary. A value of 0 selects the lower ratio (16 or 32). A value of 1 selects the doubled ratio (32 or 64).
- R7: The legal extremes work: N = 3, N = 2047, and A = 127 with N above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pre | input | 1 | Prescaler output, used as the block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| n_ratio | input | 11 | Main count N |
| a_ratio | input | 7 | Swallow count A |
| mod_sel_i | input | 1 | Prescaler range select: 0 selects the lower ratio, 1 the doubled ratio |
| mc_o | output | 1 | Modulus control: 1 selects P+1, 0 selects P |
| mod_sel_o | output | 1 | Range select latched at the period boundary |
| div_pulse_o | output | 1 | One-cycle pulse in the first prescaler cycle of each period |

## Verification
`mc_o` and `div_pulse_o` change on the same prescaler edge that ends a period, so both are valid for the whole prescaler cycle that follows. The bench reads them at the first oscillator edge of each prescaler cycle. New N, A and range values take effect only from the period that begins at the first boundary after the change. The bench therefore discards the period that ends first after each change and measures the next one. The one exception is the deferral check, which measures that first period on purpose and expects the old ratio.

// File: rtl/pss_pkg.sv
package pss_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } pss_state_e;
endpackage

// File: rtl/pss_main_cnt.sv
module pss_main_cnt #(
    parameter int N_W = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N_W-1:0] n_in,
    output logic           wrap_o,
    output logic           start_o
);
    logic [N_W-1:0] n_left;
    logic [N_W-1:0] n_lat;
    logic           start_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_left  <= '0;
            n_lat   <= '0;
            start_q <= 1'b0;
        end else if (n_left == '0) begin
            n_left  <= n_in - 1'b1;
            n_lat   <= n_in;
            start_q <= 1'b1;
        end else begin
            n_left  <= n_left - 1'b1;
            start_q <= 1'b0;
        end
    end

    always_comb begin
        wrap_o  = (n_left == '0);
        start_o = start_q;
    end

    // R2: the period pulse never lasts longer than one cycle when N is at least 2
    a_r2_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        (start_q && (n_lat > 1)) |=> !start_q);
    // R2: the remaining count stays below the latched N
    a_r2_left_below_n: assert property (@(posedge clk) disable iff (!rst_n)
        (n_lat != '0) |-> (n_left < n_lat));
    // R5: the latched N changes only at a boundary
    a_r5_n_held: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_o |=> $stable(n_lat));
endmodule

// File: rtl/pss_swallow_fsm.sv
module pss_swallow_fsm
    import pss_pkg::*;
#(
    parameter int A_W = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wrap_i,
    input  logic [A_W-1:0] a_in,
    output logic           mc_o
);
    pss_state_e     state, nxt;
    logic [A_W-1:0] a_left;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE, ST_LOW: begin
                if (wrap_i) nxt = (a_in != '0) ? ST_HIGH : ST_LOW;
            end
            ST_HIGH: begin
                if (wrap_i)              nxt = (a_in != '0) ? ST_HIGH : ST_LOW;
                else if (a_left == '0)   nxt = ST_LOW;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                a_left <= '0;
        else if (wrap_i)                           a_left <= a_in - 1'b1;
        else if (state == ST_HIGH && a_left != '0) a_left <= a_left - 1'b1;
    end

    always_comb begin
        mc_o = (state == ST_HIGH);
    end

    // R3: the swallow phase only begins at a period boundary
    a_r3_rise_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mc_o) |-> $past(wrap_i));
    // R3: the swallow phase ends once its count is used up
    a_r3_swallow_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIGH && !wrap_i && a_left == '0) |=> !mc_o);
    // R4: a zero swallow count keeps modulus control low in the new period
    a_r4_zero_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_i && a_in == '0) |=> !mc_o);
endmodule

// File: rtl/pss_divider_ctrl.sv
module pss_divider_ctrl #(
    parameter int N_W = 11,
    parameter int A_W = 7
) (
    input  logic           clk_pre,
    input  logic           rst_n,
    input  logic [N_W-1:0] n_ratio,
    input  logic [A_W-1:0] a_ratio,
    input  logic           mod_sel_i,
    output logic           mc_o,
    output logic           mod_sel_o,
    output logic           div_pulse_o
);
    logic wrap;
    logic sel_q;

    pss_main_cnt #(.N_W(N_W)) u_main (
        .clk     (clk_pre),
        .rst_n   (rst_n),
        .n_in    (n_ratio),
        .wrap_o  (wrap),
        .start_o (div_pulse_o)
    );

    pss_swallow_fsm #(.A_W(A_W)) u_fsm (
        .clk    (clk_pre),
        .rst_n  (rst_n),
        .wrap_i (wrap),
        .a_in   (a_ratio),
        .mc_o   (mc_o)
    );

    always_ff @(posedge clk_pre or negedge rst_n) begin
        if (!rst_n)    sel_q <= 1'b0;
        else if (wrap) sel_q <= mod_sel_i;
    end

    always_comb begin
        mod_sel_o = sel_q;
    end

    // R6: the range select changes only at a boundary
    a_r6_sel_held: assert property (@(posedge clk_pre) disable iff (!rst_n)
        !wrap |=> $stable(mod_sel_o));
    // R2: a pulse always follows a boundary edge
    a_r2_pulse_after_wrap: assert property (@(posedge clk_pre) disable iff (!rst_n)
        div_pulse_o |-> $past(wrap));
endmodule

// File: tb/sim_pss_divider_ctrl.sv
module sim_pss_divider_ctrl;
    typedef struct packed {
        logic [6:0]  p;
        logic        ms;
        logic [10:0] n;
        logic [6:0]  a;
        logic [16:0] exp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{7'd16, 1'b0, 11'd3,    7'd0,   17'd48},
        '{7'd16, 1'b0, 11'd3,    7'd2,   17'd50},
        '{7'd16, 1'b1, 11'd10,   7'd9,   17'd329},
        '{7'd32, 1'b1, 11'd5,    7'd4,   17'd324},
        '{7'd16, 1'b0, 11'd2047, 7'd5,   17'd32757},
        '{7'd16, 1'b1, 11'd40,   7'd0,   17'd1280},
        '{7'd16, 1'b0, 11'd200,  7'd127, 17'd3327},
        '{7'd32, 1'b0, 11'd20,   7'd7,   17'd647}
    };

    logic        vco_clk = 1'b0;
    logic        clk_pre = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] n_ratio = 11'd3;
    logic [6:0]  a_ratio = 7'd0;
    logic        mod_sel_i = 1'b0;
    logic        mc_o, mod_sel_o, div_pulse_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int pre_cnt = 0, cur_ratio = 16, p_lo = 16;
    int vco_cnt = 0, st = 0, hi = 0, np = 0, pl = 0;
    int rec_len = 0, rec_hi = 0, rec_pre = 0, rec_pls = 0;
    event ev_per;

    always #4 vco_clk = ~vco_clk;

    pss_divider_ctrl u0 (
        .clk_pre     (clk_pre),
        .rst_n       (rst_n),
        .n_ratio     (n_ratio),
        .a_ratio     (a_ratio),
        .mod_sel_i   (mod_sel_i),
        .mc_o        (mc_o),
        .mod_sel_o   (mod_sel_o),
        .div_pulse_o (div_pulse_o)
    );

    // prescaler model: one output edge every cur_ratio oscillator cycles
    always @(negedge vco_clk) begin
        if (pre_cnt >= cur_ratio - 1) begin
            pre_cnt <= 0;
            clk_pre <= 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1;
            clk_pre <= 1'b0;
        end
    end

    // per-period measurement, taken in the first oscillator cycle of each prescaler cycle
    always @(posedge vco_clk) begin
        vco_cnt = vco_cnt + 1;
        if (pre_cnt == 0) begin
            cur_ratio = (p_lo << mod_sel_o) + int'(mc_o);
            if (div_pulse_o) begin
                rec_len = vco_cnt - st;
                rec_hi  = hi;
                rec_pre = np;
                rec_pls = pl;
                st = vco_cnt; hi = 0; np = 0; pl = 0;
                -> ev_per;
            end
            hi = hi + int'(mc_o);
            np = np + 1;
            pl = pl + int'(div_pulse_o);
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (195000) @(posedge vco_clk);
        chk("watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (40) @(posedge vco_clk);
        #1;
        chk("R1 mc in reset", int'(mc_o), 0);
        chk("R1 pulse in reset", int'(div_pulse_o), 0);
        chk("R1 range in reset", int'(mod_sel_o), 0);
        @(posedge vco_clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(posedge vco_clk);
            n_ratio = VEC[i].n;
            a_ratio = VEC[i].a;
            mod_sel_i = VEC[i].ms;
            p_lo = int'(VEC[i].p);
            @(ev_per);
            @(ev_per);
            chk($sformatf("R3 ratio vec%0d", i), rec_len, int'(VEC[i].exp));
            chk($sformatf("R3 swallow cycles vec%0d", i), rec_hi, int'(VEC[i].a));
            chk($sformatf("R2 prescaler cycles vec%0d", i), rec_pre, int'(VEC[i].n));
            chk($sformatf("R2 pulse cycles vec%0d", i), rec_pls, 1);
            chk($sformatf("R6 range vec%0d", i), int'(mod_sel_o), int'(VEC[i].ms));
            if (VEC[i].a == 0)
                chk($sformatf("R4 mc low all period vec%0d", i), rec_hi, 0);
            if (VEC[i].n == 3 || VEC[i].n == 2047 || VEC[i].a == 127)
                chk($sformatf("R7 extreme vec%0d", i), rec_len, int'(VEC[i].exp));
        end

        // R5/R6: change everything right after a boundary; the running period keeps the old ratio
        @(ev_per);
        n_ratio = 11'd9;
        a_ratio = 7'd3;
        mod_sel_i = 1'b1;
        #1;
        chk("R6 range held mid-period", int'(mod_sel_o), 0);
        @(ev_per);
        chk("R5 old ratio kept", rec_len, 647);
        chk("R5 old swallow kept", rec_hi, 7);
        chk("R5 old N kept", rec_pre, 20);
        @(ev_per);
        chk("R5 new ratio applied", rec_len, 579);
        chk("R6 doubled range applied", int'(mod_sel_o), 1);
        chk("R3 new swallow count", rec_hi, 3);

        // R1: reset in the middle of a swallow phase
        @(ev_per);
        #1;
        chk("R3 mc high at period start", int'(mc_o), 1);
        rst_n = 1'b0;
        #1;
        chk("R1 mc cleared by reset", int'(mc_o), 0);
        chk("R1 pulse cleared by reset", int'(div_pulse_o), 0);
        chk("R1 range cleared by reset", int'(mod_sel_o), 0);
        repeat (5) @(posedge vco_clk);
        rst_n = 1'b1;
        @(ev_per);
        @(ev_per);
        chk("R1 ratio after reset", rec_len, 579);
        chk("R2 pulse after reset", rec_pls, 1);

        finish_run();
    end
endmodule